// File: doc/BRIEF.md
# Triple Edge-Captured Storage Bank with Shared Clock

The block holds three single-bit storage elements. Each one has its own data input, its own capture clock and its own forcing inputs for high and low. One common capture clock and one pair of global forcing inputs feed all three elements. An element loads its data when the OR of its own clock and the common clock rises. A rising edge on one clock while the other is already high has no effect, and so has no edge at all while either clock stays high. Each element drives a true output and an inverted output.

The bank works inside one free-running system clock domain. The capture clocks are treated as sampled data levels and are not real clocks. An effective edge is the sampled OR going from 0 on one system cycle to 1 on the next. The forcing inputs are also sampled on the system clock and take priority over capture. If an element sees a force-high and a force-low source in the same cycle, its true output goes low and a per-element conflict flag is raised. The flag stays up for as long as both sources remain active.

Top module: `triple_dff_bank`

## Requirements
- R1: While `rst_n` is low at a system clock edge, every `q_o` bit becomes 0, every `qn_o` bit 1 and every `conflict_o` bit 0. The effective clock history is set to high, so a clock level that is already high when reset is released is not taken as an edge.
- R2: Element i loads `data_i[i]` into `q_o[i]` on the system edge where `elem_clk_i[i] | com_clk_i` is 1 and was 0 at the previous system edge, as long as no forcing input is active.
- R3: A rising edge of `com_clk_i` while `elem_clk_i[i]` is already high does not change `q_o[i]`. The reverse case, an element clock rising while the common clock is high, also leaves it unchanged.
- R4: While the effective clock stays high or stays low, `q_o[i]` holds its value whatever `data_i[i]` does.
- R5: `dset_i[i]` high, with no low-forcing source active on element i, makes `q_o[i]` 1 at that system edge, whatever the data and clocks are.
- R6: `dclr_i[i]` high, with no high-forcing source active on element i, makes `q_o[i]` 0 at that system edge, whatever the data and clocks are.
- R7: `mset_i` acts as a force-high and `mrst_i` as a force-low on all three elements at the same time.
- R8: If a force-high source (`dset_i[i]` or `mset_i`) and a force-low source (`dclr_i[i]` or `mrst_i`) are both high on element i, then `q_o[i]` becomes 0 and `conflict_o[i]` becomes 1 at that edge. The flag returns to 0 at the first edge where the two sources are no longer both active.
- R9: After all forcing on an element is released, the element keeps its forced value until its next effective clock rising edge.
- R10: `qn_o[i]` is always the inverse of `q_o[i]`.
- R11: The elements are independent. An edge or a force on one element's own inputs does not change the other elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 3 | Data input per element |
| elem_clk_i | input | 3 | Capture clock level per element |
| com_clk_i | input | 1 | Common capture clock level |
| dset_i | input | 3 | Per-element force high |
| dclr_i | input | 3 | Per-element force low |
| mset_i | input | 1 | Global force high |
| mrst_i | input | 1 | Global force low |
| q_o | output | 3 | True outputs |
| qn_o | output | 3 | Inverted outputs |
| conflict_o | output | 3 | Per-element set/clear conflict flag |

## Verification
The hardest situation to reach is a common-clock edge that arrives while the element clock is already high. For that edge to be wrongly taken as a capture, the data must also differ from the stored bit at that moment. Directed sequences build exactly this order: raise the element clock, change the data, then raise the common clock. They then do the reverse. Random stimulus keeps the forcing inputs rare, so that long runs of capture edges mix with occasional forces, conflicts and releases. A bench model predicts each cycle.

// File: rtl/tdff_pkg.sv
// Package: shared constants and helpers for the triple storage bank.
// Assumes all control levels are already synchronous to the system clock.
package tdff_pkg;
    localparam int unsigned DEF_ELEMS = 3;

    // Resolved forcing request seen by one element.
    typedef struct packed {
        logic set;
        logic clr;
    } force_req_t;
endpackage

// File: rtl/tdff_force_merge.sv
// Module: merges the global force-high/low lines with the per-element
// direct forcing lines into one request per element.
// Assumes: purely combinational, the element module registers the result.
module tdff_force_merge
    import tdff_pkg::*;
#(
    parameter int unsigned N_ELEM = DEF_ELEMS
) (
    input  logic [N_ELEM-1:0] dset_i,
    input  logic [N_ELEM-1:0] dclr_i,
    input  logic              mset_i,
    input  logic              mrst_i,
    output force_req_t        req_o [N_ELEM]
);
    genvar g;
    generate
        for (g = 0; g < N_ELEM; g++) begin : g_merge
            // Purpose: OR the global request into each element's own request.
            always_comb begin
                req_o[g].set = dset_i[g] | mset_i;
                req_o[g].clr = dclr_i[g] | mrst_i;
            end
        end
    endgenerate
endmodule

// File: rtl/tdff_cell.sv
// Module: one storage element. It captures data on a rising edge of the
// sampled OR of its own clock and the common clock. Forcing wins over capture,
// and a simultaneous set and clear drives the output low and raises a flag.
// Assumes: clock levels are sampled data in the system clock domain.
module tdff_cell
    import tdff_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_i,
    input  logic       elem_clk_i,
    input  logic       com_clk_i,
    input  force_req_t req_i,
    output logic       q_o,
    output logic       qn_o,
    output logic       conflict_o
);
    logic eff_clk;
    logic prev_eff_q;
    logic edge_seen;
    logic q_q;
    logic conf_q;

    // Purpose: form the effective clock level and detect its rising edge.
    always_comb begin
        eff_clk   = elem_clk_i | com_clk_i;
        edge_seen = eff_clk & ~prev_eff_q;
    end

    // Purpose: remember the previous effective clock level (reset high).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_eff_q <= 1'b1;
        else        prev_eff_q <= eff_clk;
    end

    // Purpose: the stored bit, with forcing taking priority over capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                        q_q <= 1'b0;
        else if (req_i.set && req_i.clr)   q_q <= 1'b0;
        else if (req_i.set)                q_q <= 1'b1;
        else if (req_i.clr)                q_q <= 1'b0;
        else if (edge_seen)                q_q <= data_i;
    end

    // Purpose: flag a set/clear conflict for as long as it lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) conf_q <= 1'b0;
        else        conf_q <= req_i.set & req_i.clr;
    end

    // Purpose: drive the true and inverted outputs.
    always_comb begin
        q_o        = q_q;
        qn_o       = ~q_q;
        conflict_o = conf_q;
    end

    a_r5_set_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i.set && !req_i.clr) |=> q_o);
    a_r6_clr_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i.clr && !req_i.set) |=> !q_o);
    a_r8_conflict_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i.set && req_i.clr) |=> (conflict_o && !q_o));
    a_r8_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i.set && req_i.clr) |=> !conflict_o);
    a_r4_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i.set && !req_i.clr && (prev_eff_q || !eff_clk)) |=> $stable(q_o));
    a_r2_capture_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i.set && !req_i.clr && !prev_eff_q && eff_clk) |=> (q_o == $past(data_i)));
    a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qn_o != q_o));
endmodule

// File: rtl/triple_dff_bank.sv
// Module: top of the bank. It merges the forcing lines and builds one cell
// per element.
// Assumes: a single system clock; all inputs synchronous to it.
module triple_dff_bank
    import tdff_pkg::*;
#(
    parameter int unsigned N_ELEM = DEF_ELEMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ELEM-1:0] data_i,
    input  logic [N_ELEM-1:0] elem_clk_i,
    input  logic              com_clk_i,
    input  logic [N_ELEM-1:0] dset_i,
    input  logic [N_ELEM-1:0] dclr_i,
    input  logic              mset_i,
    input  logic              mrst_i,
    output logic [N_ELEM-1:0] q_o,
    output logic [N_ELEM-1:0] qn_o,
    output logic [N_ELEM-1:0] conflict_o
);
    force_req_t req [N_ELEM];

    tdff_force_merge #(.N_ELEM(N_ELEM)) u_merge (
        .dset_i (dset_i),
        .dclr_i (dclr_i),
        .mset_i (mset_i),
        .mrst_i (mrst_i),
        .req_o  (req)
    );

    genvar g;
    generate
        for (g = 0; g < N_ELEM; g++) begin : g_cell
            tdff_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .data_i     (data_i[g]),
                .elem_clk_i (elem_clk_i[g]),
                .com_clk_i  (com_clk_i),
                .req_i      (req[g]),
                .q_o        (q_o[g]),
                .qn_o       (qn_o[g]),
                .conflict_o (conflict_o[g])
            );
        end
    endgenerate

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0 && conflict_o == '0));
endmodule

// File: tb/test_triple_dff_bank.sv
module test_triple_dff_bank;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] data_i, elem_clk_i, dset_i, dclr_i;
    logic         com_clk_i, mset_i, mrst_i;
    logic [N-1:0] q_o, qn_o, conflict_o;

    int checks = 0;
    int errors = 0;

    // Reference state, computed from the requirements.
    logic [N-1:0] m_q, m_conf, m_prev;
    string        m_tag [N];

    always #2.5 clk = ~clk;

    triple_dff_bank i_triple_dff_bank (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .elem_clk_i(elem_clk_i),
        .com_clk_i(com_clk_i), .dset_i(dset_i), .dclr_i(dclr_i),
        .mset_i(mset_i), .mrst_i(mrst_i), .q_o(q_o), .qn_o(qn_o),
        .conflict_o(conflict_o)
    );

    // Reference step for one element; returns the requirement it exercises.
    function automatic string ref_step(int i);
        logic s, c, e;
        string t;
        s = dset_i[i] | mset_i;
        c = dclr_i[i] | mrst_i;
        e = elem_clk_i[i] | com_clk_i;
        if (!rst_n) begin
            m_q[i] = 1'b0; m_conf[i] = 1'b0; m_prev[i] = 1'b1; return "R1";
        end
        m_conf[i] = s & c;
        if (s && c)      begin m_q[i] = 1'b0; t = "R8"; end
        else if (s)      begin m_q[i] = 1'b1; t = mset_i ? "R7" : "R5"; end
        else if (c)      begin m_q[i] = 1'b0; t = mrst_i ? "R7" : "R6"; end
        else if (e && !m_prev[i]) begin m_q[i] = data_i[i]; t = "R2"; end
        else t = "R4";
        m_prev[i] = e;
        return t;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One system cycle: inputs already set, model follows the edge, compare.
    task automatic step(string force_tag = "");
        @(posedge clk);
        for (int i = 0; i < N; i++) m_tag[i] = ref_step(i);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            string t;
            t = (force_tag != "") ? force_tag : m_tag[i];
            chk(t, $sformatf("q[%0d]", i), q_o[i], m_q[i]);
            chk(t, $sformatf("conflict[%0d]", i), conflict_o[i], m_conf[i]);
            chk("R10", $sformatf("qn[%0d]", i), qn_o[i], ~q_o[i]);
        end
    endtask

    task automatic idle();
        data_i = '0; elem_clk_i = '0; com_clk_i = 0;
        dset_i = '0; dclr_i = '0; mset_i = 0; mrst_i = 0;
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        idle();
        rst_n = 1'b0;
        elem_clk_i = 3'b111;
        @(negedge clk);
        repeat (3) step("R1");
        rst_n = 1'b1;
        data_i = 3'b111;
        step("R1");                 // clock already high: no capture
        // R2: fall then rise of element clocks captures
        elem_clk_i = '0; step("R4");
        elem_clk_i = 3'b111; step("R2");
        // R3: element clock high, data flips, common rises -> hold
        data_i = 3'b000; com_clk_i = 1; step("R3");
        com_clk_i = 0; elem_clk_i = 0; step("R4");
        com_clk_i = 1; step("R2");   // captures 0
        data_i = 3'b101; elem_clk_i = 3'b101; step("R3");
        idle(); step("R4");
        // R11: only element 1 clocks
        data_i = 3'b111; elem_clk_i = 3'b010; step("R11");
        // R5/R6 with clocks low, then R9 release holds
        elem_clk_i = 0; dset_i = 3'b001; dclr_i = 3'b100; step();
        dset_i = 0; dclr_i = 0; data_i = 3'b000; step("R9");
        step("R9");
        // R7 global forces
        mset_i = 1; step("R7");
        mset_i = 0; mrst_i = 1; step("R7");
        // R8 conflict, persists, then drops
        mrst_i = 0; mset_i = 1; dclr_i = 3'b010; step("R8");
        step("R8");
        dclr_i = 0; step("R8");
        mset_i = 0; step("R9");
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            data_i     = 3'($urandom);
            elem_clk_i = 3'($urandom);
            com_clk_i  = ($urandom % 3) == 0;
            dset_i     = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            dclr_i     = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            mset_i     = ($urandom % 24) == 0;
            mrst_i     = ($urandom % 24) == 0;
            step();
        end
        // Reset mid-run
        rst_n = 0; step("R1"); rst_n = 1; idle(); step("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule